// File: doc/BRIEF.md
# Rotate, Shift and Bit Unit

An 8-bit datapath slice for a small accumulator CPU that performs the prefixed bit-manipulation operations: rotates (with and without the carry in the loop), shifts (arithmetic left, arithmetic right, logical right), nibble swap, and single-bit test, set and clear. The short accumulator-only rotate forms are also provided. They compute the same data result as the general rotates but follow a different zero-flag rule.

The caller supplies an operation code, a bit index, the operand and the current flag nibble with `valid_i`. One clock later the unit presents the result, a write enable for the destination and the new flag nibble. Operand fetch and instruction timing belong to the surrounding core. The flag nibble is ordered {Z, N, H, C}: Z is bit 3, N is bit 2, H is bit 1 and C is bit 0. The incoming carry is `flags_i[0]`.

Operation codes on `op_i`:

| Code | Operation |
|------|-----------|
| 0 | rotate left, bit 7 into C and bit 0 |
| 1 | rotate right, bit 0 into C and bit 7 |
| 2 | rotate left through carry |
| 3 | rotate right through carry |
| 4 | arithmetic shift left |
| 5 | arithmetic shift right |
| 6 | swap nibbles |
| 7 | logical shift right |
| 8 | bit test |
| 9 | bit clear |
| 10 | bit set |
| 11 | accumulator rotate left |
| 12 | accumulator rotate right |
| 13 | accumulator rotate left through carry |
| 14 | accumulator rotate right through carry |
| 15 | pass through |

Top module: `rsb_unit`

## Requirements
- R1: While `rst_ni` is low and until the first accepted operation, `valid_o`, `wr_en_o`, `result_o` and `flags_o` are all 0.
- R2: An operation accepted with `valid_i`=1 shows its outputs after exactly one clock edge, with `valid_o`=1. A cycle with `valid_i`=0 drives `valid_o` to 0 and leaves `result_o`, `wr_en_o` and `flags_o` unchanged.
- R3: Left rotates. For codes 0 and 11, bit 7 moves to both C and bit 0. For codes 2 and 13, bit 7 moves to C and the old C (`flags_i[0]`) moves to bit 0. All other bits move up by one.
- R4: Right rotates. For codes 1 and 12, bit 0 moves to both C and bit 7. For codes 3 and 14, bit 0 moves to C and the old C moves to bit 7. All other bits move down by one.
- R5: Shifts. Code 4 moves bit 7 to C and fills bit 0 with 0. Code 5 keeps bit 7 unchanged. Code 7 fills bit 7 with 0. Codes 5 and 7 move bit 0 to C.
- R6: For codes 0 to 5 and 7, Z is set exactly when the 8-bit result is 0, and N and H are 0.
- R7: For codes 11 to 14, Z, N and H are 0 whatever the result is.
- R8: Code 6 exchanges bits 7:4 with bits 3:0. Z is set from the result, and N, H and C are 0.
- R9: Code 8 sets Z to the inverse of operand bit `bit_idx_i`, sets N to 0 and H to 1, and keeps C from `flags_i[0]`.
- R10: Code 8 drives `wr_en_o` to 0 and returns the operand unchanged on `result_o`. Every other code drives `wr_en_o` to 1.
- R11: Code 9 clears and code 10 sets only operand bit `bit_idx_i`, where bit 0 is the LSB. For both codes `flags_o` equals `flags_i`.
- R12: Code 15 returns the operand unchanged and `flags_o` equals `flags_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit index for test, set and clear |
| operand_i | input | 8 | Operand |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| valid_o | output | 1 | Result valid |
| result_o | output | 8 | Result |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | New flags {Z,N,H,C} |

## Verification
The bench builds the unit with its default 8-bit data width and 3-bit bit index. At these values, random operands together with directed all-zero and single-bit patterns reach every bit position and both values of the incoming carry. Results of zero after a rotate or shift are forced deliberately. This brings the split between R6 and R7 on the zero flag within reach, along with test, set and clear at both end bits.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  typedef enum logic [3:0] {
    OP_RLC  = 4'd0,
    OP_RRC  = 4'd1,
    OP_RL   = 4'd2,
    OP_RR   = 4'd3,
    OP_SLA  = 4'd4,
    OP_SRA  = 4'd5,
    OP_SWAP = 4'd6,
    OP_SRL  = 4'd7,
    OP_BIT  = 4'd8,
    OP_RES  = 4'd9,
    OP_SET  = 4'd10,
    OP_RLCA = 4'd11,
    OP_RRCA = 4'd12,
    OP_RLA  = 4'd13,
    OP_RRA  = 4'd14,
    OP_PASS = 4'd15
  } rsb_op_e;

  localparam int unsigned FLAG_Z = 3;
  localparam int unsigned FLAG_N = 2;
  localparam int unsigned FLAG_H = 1;
  localparam int unsigned FLAG_C = 0;
  localparam int unsigned FLAGS_W = 4;
endpackage

// File: rtl/rsb_shift.sv
module rsb_shift
  import rsb_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  rsb_op_e           op_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] data_o,
  output logic              cout_o
);
  localparam int unsigned HALF_W = DATA_W / 2;

  logic msb, lsb;
  assign msb = data_i[DATA_W-1];
  assign lsb = data_i[0];

  always_comb begin
    data_o = data_i;
    cout_o = cin_i;
    unique case (op_i)
      OP_RLC, OP_RLCA: begin data_o = {data_i[DATA_W-2:0], msb};  cout_o = msb; end
      OP_RL,  OP_RLA:  begin data_o = {data_i[DATA_W-2:0], cin_i}; cout_o = msb; end
      OP_RRC, OP_RRCA: begin data_o = {lsb, data_i[DATA_W-1:1]};  cout_o = lsb; end
      OP_RR,  OP_RRA:  begin data_o = {cin_i, data_i[DATA_W-1:1]}; cout_o = lsb; end
      OP_SLA:          begin data_o = {data_i[DATA_W-2:0], 1'b0}; cout_o = msb; end
      OP_SRA:          begin data_o = {msb, data_i[DATA_W-1:1]};  cout_o = lsb; end
      OP_SRL:          begin data_o = {1'b0, data_i[DATA_W-1:1]}; cout_o = lsb; end
      OP_SWAP:         begin data_o = {data_i[HALF_W-1:0], data_i[DATA_W-1:HALF_W]}; cout_o = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/rsb_bitop.sv
module rsb_bitop #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              set_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] mask;

  for (genvar g = 0; g < DATA_W; g++) begin : g_mask
    assign mask[g] = (idx_i == IDX_W'(g));
  end

  assign bit_o  = |(data_i & mask);
  assign data_o = set_i ? (data_i | mask) : (data_i & ~mask);
endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [3:0]        flags_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              wr_en_o,
  output logic [3:0]        flags_o
);
  rsb_op_e op;
  assign op = rsb_op_e'(op_i);

  logic [DATA_W-1:0] sh_data, bo_data, res_d;
  logic              sh_cout, bo_bit, wr_d;
  logic [3:0]        flg_d;

  rsb_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i   (op),
    .data_i (operand_i),
    .cin_i  (flags_i[FLAG_C]),
    .data_o (sh_data),
    .cout_o (sh_cout)
  );

  rsb_bitop #(.DATA_W(DATA_W)) u_bitop (
    .data_i (operand_i),
    .idx_i  (bit_idx_i),
    .set_i  (op == OP_SET),
    .data_o (bo_data),
    .bit_o  (bo_bit)
  );

  always_comb begin
    res_d = operand_i;
    flg_d = flags_i;
    wr_d  = 1'b1;
    unique case (op)
      OP_RLC, OP_RRC, OP_RL, OP_RR, OP_SLA, OP_SRA, OP_SRL, OP_SWAP: begin
        res_d = sh_data;
        flg_d = {(sh_data == '0), 1'b0, 1'b0, sh_cout};
      end
      OP_RLCA, OP_RRCA, OP_RLA, OP_RRA: begin
        res_d = sh_data;
        flg_d = {3'b000, sh_cout};
      end
      OP_BIT: begin
        wr_d  = 1'b0;
        flg_d = {~bo_bit, 1'b0, 1'b1, flags_i[FLAG_C]};
      end
      OP_RES, OP_SET: res_d = bo_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      wr_en_o  <= 1'b0;
      flags_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        wr_en_o  <= wr_d;
        flags_o  <= flg_d;
      end
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o) && $stable(wr_en_o));

  // R7
  acc_rot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd11, 4'd12, 4'd13, 4'd14}) |=> flags_o[3:1] == 3'b000);

  // R8
  swap_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd6 |=> flags_o[2:0] == 3'b000);

  // R9
  bit_test_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd8 |=> flags_o[2:1] == 2'b01 && flags_o[0] == $past(flags_i[0]));

  // R10
  bit_test_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'd8 |=> !wr_en_o && result_o == $past(operand_i));

  // R11
  set_clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'd9, 4'd10}) |=> flags_o == $past(flags_i) && wr_en_o);
endmodule

// File: tb/rsb_unit_test.sv
module rsb_unit_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [3:0] op_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] operand_i = '0;
  logic [3:0] flags_i = '0;
  logic       valid_o, wr_en_o;
  logic [7:0] result_o;
  logic [3:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  rsb_unit uut (
    .clk_i, .rst_ni, .valid_i, .op_i, .bit_idx_i, .operand_i, .flags_i,
    .valid_o, .result_o, .wr_en_o, .flags_o
  );

  always #2 clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected {wr, flags, result}
  function automatic logic [12:0] model(input logic [3:0] op, input logic [2:0] idx,
                                        input logic [7:0] d, input logic [3:0] f);
    logic [7:0] r;
    logic c, z, n, h, w;
    r = d; c = f[0]; z = f[3]; n = f[2]; h = f[1]; w = 1'b1;
    case (op)
      4'd0, 4'd11: begin r = {d[6:0], d[7]}; c = d[7]; end
      4'd1, 4'd12: begin r = {d[0], d[7:1]}; c = d[0]; end
      4'd2, 4'd13: begin r = {d[6:0], f[0]}; c = d[7]; end
      4'd3, 4'd14: begin r = {f[0], d[7:1]}; c = d[0]; end
      4'd4: begin r = d << 1; c = d[7]; end
      4'd5: begin r = {d[7], d[7:1]}; c = d[0]; end
      4'd6: begin r = {d[3:0], d[7:4]}; c = 1'b0; end
      4'd7: begin r = d >> 1; c = d[0]; end
      4'd8: begin w = 1'b0; z = ~d[idx]; n = 0; h = 1; end
      4'd9: r[idx] = 1'b0;
      4'd10: r[idx] = 1'b1;
      default: ;
    endcase
    if (op <= 4'd7) begin z = (r == 8'd0); n = 0; h = 0; end
    if (op >= 4'd11 && op <= 4'd14) begin z = 0; n = 0; h = 0; end
    return {w, z, n, h, c, r};
  endfunction

  function automatic string res_tag(input logic [3:0] op);
    case (op)
      4'd0, 4'd2, 4'd11, 4'd13: return "R3";
      4'd1, 4'd3, 4'd12, 4'd14: return "R4";
      4'd4, 4'd5, 4'd7: return "R5";
      4'd6: return "R8";
      4'd8: return "R10";
      4'd9, 4'd10: return "R11";
      default: return "R12";
    endcase
  endfunction

  function automatic string flg_tag(input logic [3:0] op);
    if (op <= 4'd5 || op == 4'd7) return "R6";
    if (op >= 4'd11 && op <= 4'd14) return "R7";
    if (op == 4'd6) return "R8";
    if (op == 4'd8) return "R9";
    if (op == 4'd15) return "R12";
    return "R11";
  endfunction

  task automatic run(input logic [3:0] op, input logic [2:0] idx,
                     input logic [7:0] d, input logic [3:0] f);
    logic [12:0] e;
    e = model(op, idx, d, f);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; bit_idx_i = idx; operand_i = d; flags_i = f;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R2", int'(valid_o), 1);
    check(res_tag(op), int'(result_o), int'(e[7:0]));
    check(flg_tag(op), int'(flags_o), int'(e[11:8]));
    check("R10", int'(wr_en_o), int'(e[12]));
  endtask

  initial begin
    #100000;
    $display("FAIL watchdog expired actual=0 expected=1");
    errors++; checks++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rs, fs;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1
    check("R1", int'({valid_o, wr_en_o, flags_o, result_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'({valid_o, wr_en_o, flags_o, result_o}), 0);

    // directed corners
    run(4'd0, 0, 8'h80, 4'h0);
    run(4'd2, 0, 8'h80, 4'h0);  // R6: zero result
    run(4'd13, 0, 8'h80, 4'h0); // R7: zero result, Z cleared
    run(4'd3, 0, 8'h01, 4'h0);
    run(4'd14, 0, 8'h01, 4'h1);
    run(4'd1, 0, 8'h01, 4'hF);
    run(4'd12, 0, 8'h00, 4'hF);
    run(4'd5, 0, 8'h81, 4'h0);
    run(4'd7, 0, 8'h81, 4'h0);
    run(4'd4, 0, 8'h80, 4'h0);
    run(4'd6, 0, 8'hA5, 4'hF);
    run(4'd6, 0, 8'h00, 4'h1);
    run(4'd8, 3'd7, 8'h7F, 4'h1);
    run(4'd8, 3'd0, 8'h01, 4'h0);
    run(4'd9, 3'd7, 8'hFF, 4'hA);
    run(4'd10, 3'd0, 8'h00, 4'h5);
    run(4'd15, 0, 8'h3C, 4'h9);

    // R2: hold while idle
    rs = result_o; fs = {4'h0, flags_o};
    @(negedge clk_i);
    op_i = 4'd6; operand_i = 8'h12; flags_i = 4'hF;
    @(negedge clk_i);
    check("R2", int'(valid_o), 0);
    check("R2", int'(result_o), int'(rs));
    check("R2", int'(flags_o), int'(fs[3:0]));
    check("R2", int'(wr_en_o), 1);

    for (int i = 0; i < 400; i++) begin
      run(4'($urandom), 3'($urandom), 8'($urandom), 4'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule